// File: doc/BRIEF.md
# Manual DMA Event Trigger Bank

This block holds 64 event bits that software raises by hand to request DMA transfers without a peripheral trigger. The bits are split into a low and a high 32-bit word. A CPU write of 1 to a bit makes that event pending. Writes of 0 do nothing. A pending bit cannot be withdrawn by software. Only the submission path removes it, on the cycle its transfer request is accepted downstream. No enable mask qualifies these events.

A fixed-priority selector offers the lowest-numbered pending event on a valid/ready submission port. When the handshake completes, that event's bit is cleared. When a write of 1 hits a bit that is already pending, one request is lost. The block records this in a sticky missed-event word, which software clears by writing 1s to a separate clear address.

The register address is `{kind[1:0], word}`, with `word` selecting the low (0) or high (1) 32-bit half. The kinds are:
- 0: trigger set
- 1: trigger clear (accepted but ignored)
- 2: missed status
- 3: missed clear

Top module: `evt_manual_set`

## Requirements
- R1: A write to kind 0 sets every event bit whose data bit is 1. Event n sits in word n/32, at bit n%32. Data bits of 0 leave their events unchanged.
- R2: A write to kind 1 (trigger clear) with any data leaves every pending bit unchanged. Pending bits are not gated by any enable.
- R3: A pending bit clears only at the clock edge where the submission handshake (`sub_valid` and `sub_ready` both high) completes with `sub_idx` equal to that bit.
- R4: When a set write and a handshake act in the same cycle, the set wins. If the handshake clears the same bit, that bit stays pending and its missed bit is set. If the handshake clears a different bit, the written bit becomes pending with no missed indication.
- R5: A write of 1 to an event bit that is already pending sets that event's missed bit. The pending bit stays set.
- R6: Missed bits are sticky. A write to kind 3 clears exactly the missed bits whose data bit is 1.
- R7: `sub_valid` is high exactly when any bit is pending, and `sub_idx` gives the lowest-numbered pending event. While `sub_ready` is low, `sub_valid` stays high.
- R8: Reads are combinational. Kind 0 returns the pending word and kind 2 returns the missed word. Kinds 1 and 3 read as zero.
- R9: After reset, all pending and missed bits are zero and `sub_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Write address {kind, word} |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 3 | Read address {kind, word} |
| reg_rd_data | output | 32 | Combinational read data |
| sub_valid | output | 1 | A pending event is offered |
| sub_idx | output | 6 | Number of the offered event |
| sub_ready | input | 1 | Downstream accepts the offered event |

## Verification
The bench raises events at different positions to separate lower-half from upper-half decoding and to expose ordering errors:
- a mixed pattern spread over both words;
- a single bit;
- event 63 alone.

Writes of zero data and all-ones writes to the trigger-clear address check that nothing but a set write or the handshake moves a bit. Repeated set writes and same-cycle set/handshake collisions are driven both on the bit being accepted and on a different bit. These runs separate "set wins with a miss" from "set wins without a miss". Holding `sub_ready` low confirms that an offered event waits rather than disappears.

// File: rtl/evs_pkg.sv
`timescale 1ns/1ps
package evs_pkg;

   typedef enum logic [1:0] {
      KIND_SET  = 2'd0,
      KIND_ECLR = 2'd1,
      KIND_MISS = 2'd2,
      KIND_MCLR = 2'd3
   } evs_kind_e;

   // width of a selector field, never below one bit
   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/evs_regif.sv
`timescale 1ns/1ps
module evs_regif
   import evs_pkg::*;
#(
   parameter  int unsigned NUM_EVT  = 64,
   parameter  int unsigned REG_W    = 32,
   localparam int unsigned NUM_REGS = NUM_EVT / REG_W,
   localparam int unsigned WSEL_W   = sel_width(NUM_REGS),
   localparam int unsigned ADDR_W   = WSEL_W + 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NUM_EVT-1:0] pend,
   input  logic [NUM_EVT-1:0] miss,
   output logic [NUM_EVT-1:0] set_vec,
   output logic [NUM_EVT-1:0] mclr_vec,
   output logic [REG_W-1:0]  rd_data
);

   logic [1:0]        wr_kind;
   logic [WSEL_W-1:0] wr_word;
   logic [1:0]        rd_kind;
   logic [WSEL_W-1:0] rd_word;

   assign {wr_kind, wr_word} = wr_addr;
   assign {rd_kind, rd_word} = rd_addr;

   // per-word write decode; trigger-clear writes are deliberately not decoded
   for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_word == WSEL_W'(w));
      assign set_vec[w*REG_W +: REG_W] =
         (hit && wr_kind == KIND_SET) ? wr_data : '0;
      assign mclr_vec[w*REG_W +: REG_W] =
         (hit && wr_kind == KIND_MCLR) ? wr_data : '0;
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NUM_REGS; w++) begin
         if (rd_word == WSEL_W'(w)) begin
            if (rd_kind == KIND_SET)
               rd_data = pend[w*REG_W +: REG_W];
            else if (rd_kind == KIND_MISS)
               rd_data = miss[w*REG_W +: REG_W];
         end
      end
   end

endmodule

// File: rtl/evs_bit_bank.sv
`timescale 1ns/1ps
module evs_bit_bank #(
   parameter int unsigned NUM_EVT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_vec,
   input  logic [NUM_EVT-1:0] clr_vec,
   input  logic [NUM_EVT-1:0] mclr_vec,
   output logic [NUM_EVT-1:0] pend,
   output logic [NUM_EVT-1:0] miss
);

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic p_q;
      logic m_q;
      logic lost;

      // a set landing on a bit that is still pending loses one request
      assign lost = set_vec[i] & p_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            m_q <= 1'b0;
         end else begin
            p_q <= set_vec[i] | (p_q & ~clr_vec[i]);
            m_q <= lost | (m_q & ~mclr_vec[i]);
         end
      end

      assign pend[i] = p_q;
      assign miss[i] = m_q;
   end

endmodule

// File: rtl/evs_prio_pick.sv
`timescale 1ns/1ps
module evs_prio_pick
   import evs_pkg::*;
#(
   parameter  int unsigned NUM_EVT = 64,
   parameter  int unsigned GROUP_W = 32,
   parameter  bit          HIER    = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_EVT)
) (
   input  logic [NUM_EVT-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   assign any = |req;

   if (HIER) begin : g_hier
      localparam int unsigned NGRP  = NUM_EVT / GROUP_W;
      localparam int unsigned LOC_W = sel_width(GROUP_W);

      logic [NGRP-1:0]  g_any;
      logic [LOC_W-1:0] g_loc [NGRP];

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         logic [GROUP_W-1:0] slice;
         logic [LOC_W-1:0]   loc;

         assign slice    = req[g*GROUP_W +: GROUP_W];
         assign g_any[g] = |slice;

         always_comb begin
            loc = '0;
            for (int b = GROUP_W - 1; b >= 0; b--)
               if (slice[b]) loc = LOC_W'(b);
         end

         assign g_loc[g] = loc;
      end

      always_comb begin
         idx = '0;
         for (int g = NGRP - 1; g >= 0; g--)
            if (g_any[g]) idx = IDX_W'(g * GROUP_W) + IDX_W'(g_loc[g]);
      end
   end else begin : g_flat
      always_comb begin
         idx = '0;
         for (int i = NUM_EVT - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/evt_manual_set.sv
`timescale 1ns/1ps
module evt_manual_set
   import evs_pkg::*;
#(
   parameter  int unsigned NUM_EVT   = 64,
   parameter  int unsigned REG_W     = 32,
   parameter  bit          PICK_HIER = 1'b1,
   localparam int unsigned NUM_REGS  = NUM_EVT / REG_W,
   localparam int unsigned WSEL_W    = sel_width(NUM_REGS),
   localparam int unsigned ADDR_W    = WSEL_W + 2,
   localparam int unsigned IDX_W     = $clog2(NUM_EVT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_wr_addr,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic [ADDR_W-1:0] reg_rd_addr,
   output logic [REG_W-1:0]  reg_rd_data,
   output logic              sub_valid,
   output logic [IDX_W-1:0]  sub_idx,
   input  logic              sub_ready
);

   if (NUM_EVT < 2) begin : g_bad_num
      $error("NUM_EVT must be at least 2");
   end
   if (REG_W < 2) begin : g_bad_regw
      $error("REG_W must be at least 2");
   end
   if (NUM_EVT % REG_W != 0) begin : g_bad_split
      $error("NUM_EVT must be a multiple of REG_W");
   end

   logic [NUM_EVT-1:0] pend_q;
   logic [NUM_EVT-1:0] miss_q;
   logic [NUM_EVT-1:0] set_vec;
   logic [NUM_EVT-1:0] mclr_vec;
   logic [NUM_EVT-1:0] clr_vec;
   logic               hs;

   evs_regif #(
      .NUM_EVT (NUM_EVT),
      .REG_W   (REG_W)
   ) u_regif (
      .wr_en    (reg_wr_en),
      .wr_addr  (reg_wr_addr),
      .wr_data  (reg_wr_data),
      .rd_addr  (reg_rd_addr),
      .pend     (pend_q),
      .miss     (miss_q),
      .set_vec  (set_vec),
      .mclr_vec (mclr_vec),
      .rd_data  (reg_rd_data)
   );

   evs_bit_bank #(
      .NUM_EVT (NUM_EVT)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .mclr_vec (mclr_vec),
      .pend     (pend_q),
      .miss     (miss_q)
   );

   evs_prio_pick #(
      .NUM_EVT (NUM_EVT),
      .GROUP_W (REG_W),
      .HIER    (PICK_HIER)
   ) u_pick (
      .req (pend_q),
      .any (sub_valid),
      .idx (sub_idx)
   );

   assign hs = sub_valid & sub_ready;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
      assign clr_vec[i] = hs && (sub_idx == IDX_W'(i));
   end

endmodule

// File: rtl/evs_chk.sv
`timescale 1ns/1ps
module evs_chk
   import evs_pkg::*;
#(
   parameter  int unsigned NUM_EVT  = 64,
   parameter  int unsigned REG_W    = 32,
   localparam int unsigned NUM_REGS = NUM_EVT / REG_W,
   localparam int unsigned WSEL_W   = sel_width(NUM_REGS),
   localparam int unsigned ADDR_W   = WSEL_W + 2,
   localparam int unsigned IDX_W    = $clog2(NUM_EVT)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [REG_W-1:0]   wr_data,
   input logic               sub_valid,
   input logic               sub_ready,
   input logic [IDX_W-1:0]   sub_idx,
   input logic [NUM_EVT-1:0] pend,
   input logic [NUM_EVT-1:0] miss
);

   logic [NUM_EVT-1:0] w_set;
   logic [NUM_EVT-1:0] w_mclr;
   logic [NUM_EVT-1:0] hs_vec;
   logic [NUM_EVT-1:0] low_mask;

   always_comb begin
      w_set  = '0;
      w_mclr = '0;
      for (int w = 0; w < NUM_REGS; w++) begin
         if (wr_en && wr_addr[WSEL_W-1:0] == WSEL_W'(w)) begin
            if (wr_addr[ADDR_W-1 -: 2] == KIND_SET)
               w_set[w*REG_W +: REG_W] = wr_data;
            if (wr_addr[ADDR_W-1 -: 2] == KIND_MCLR)
               w_mclr[w*REG_W +: REG_W] = wr_data;
         end
      end
      hs_vec = '0;
      if (sub_valid && sub_ready) hs_vec[sub_idx] = 1'b1;
      low_mask = (NUM_EVT'(1) << sub_idx) - NUM_EVT'(1);
   end

   // R1
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_set != '0) |=> ((pend & $past(w_set)) == $past(w_set)));

   // R2
   rise_only_by_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(w_set)) == '0));

   // R3
   fall_only_by_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~pend & ~$past(hs_vec)) == '0));

   // R5
   miss_on_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((w_set & pend) != '0) |=> ((miss & $past(w_set & pend)) == $past(w_set & pend)));

   // R6
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(miss) & ~miss & ~$past(w_mclr)) == '0));

   // R7
   lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> (pend[sub_idx] && ((pend & low_mask) == '0)));

   // R7
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && !sub_ready) |=> sub_valid);

   // R9
   reset_clean_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (pend == '0 && miss == '0));

endmodule

bind evt_manual_set evs_chk #(
   .NUM_EVT (NUM_EVT),
   .REG_W   (REG_W)
) u_evs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (reg_wr_en),
   .wr_addr   (reg_wr_addr),
   .wr_data   (reg_wr_data),
   .sub_valid (sub_valid),
   .sub_ready (sub_ready),
   .sub_idx   (sub_idx),
   .pend      (pend_q),
   .miss      (miss_q)
);

// File: tb/tb_evt_manual_set.sv
`timescale 1ns/1ps
module tb_evt_manual_set;

   localparam logic [2:0] A_SET_LO  = 3'd0;
   localparam logic [2:0] A_SET_HI  = 3'd1;
   localparam logic [2:0] A_ECLR_LO = 3'd2;
   localparam logic [2:0] A_ECLR_HI = 3'd3;
   localparam logic [2:0] A_MISS_LO = 3'd4;
   localparam logic [2:0] A_MISS_HI = 3'd5;
   localparam logic [2:0] A_MCLR_LO = 3'd6;
   localparam logic [2:0] A_MCLR_HI = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        sub_valid;
   logic [5:0]  sub_idx;
   logic        sub_ready = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   evt_manual_set dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (wr_en),
      .reg_wr_addr (wr_addr),
      .reg_wr_data (wr_data),
      .reg_rd_addr (rd_addr),
      .reg_rd_data (rd_data),
      .sub_valid   (sub_valid),
      .sub_idx     (sub_idx),
      .sub_ready   (sub_ready)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic rd_pend(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(A_SET_LO, lo); rd(A_SET_HI, hi);
      v = {hi, lo};
   endtask

   task automatic rd_miss(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(A_MISS_LO, lo); rd(A_MISS_HI, hi);
      v = {hi, lo};
   endtask

   task automatic accept_one(output logic [5:0] idx);
      @(negedge clk);
      idx = sub_idx;
      sub_ready = 1'b1;
      @(negedge clk);
      sub_ready = 1'b0;
   endtask

   task automatic drain();
      logic [5:0] junk;
      for (int k = 0; k < 80 && sub_valid; k++) accept_one(junk);
      wr(A_MCLR_LO, 32'hFFFF_FFFF);
      wr(A_MCLR_HI, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R9 register zero after reset", 64'(d), 64'h0);
      end
      chk("R9 sub_valid low after reset", 64'(sub_valid), 64'h0);
   endtask

   task automatic t_set_and_order();
      logic [63:0] v;
      logic [5:0]  idx;
      wr(A_SET_LO, 32'h0000_0011);
      wr(A_SET_HI, 32'h8000_0000);
      rd_pend(v);
      chk("R1 pending after set writes", v, 64'h8000_0000_0000_0011);
      wr(A_SET_LO, 32'h0);
      rd_pend(v);
      chk("R1 zero write no effect", v, 64'h8000_0000_0000_0011);
      rd_miss(v);
      chk("R5 fresh bits give no miss", v, 64'h0);
      chk("R7 valid with pending", 64'(sub_valid), 64'h1);
      accept_one(idx);
      chk("R7 first offered index", 64'(idx), 64'd0);
      rd_pend(v);
      chk("R3 bit 0 cleared after accept", v, 64'h8000_0000_0000_0010);
      accept_one(idx);
      chk("R7 second offered index", 64'(idx), 64'd4);
      accept_one(idx);
      chk("R7 third offered index", 64'(idx), 64'd63);
      rd_pend(v);
      chk("R3 all cleared after accepts", v, 64'h0);
      chk("R7 valid low when empty", 64'(sub_valid), 64'h0);
   endtask

   task automatic t_eclr_and_hold();
      logic [63:0] v;
      logic [31:0] d;
      wr(A_SET_LO, 32'h0000_0080);
      wr(A_SET_HI, 32'h0000_0002);
      wr(A_ECLR_LO, 32'hFFFF_FFFF);
      wr(A_ECLR_HI, 32'hFFFF_FFFF);
      rd_pend(v);
      chk("R2 trigger-clear write ignored", v, 64'h0000_0002_0000_0080);
      rd(A_ECLR_LO, d);
      chk("R8 trigger-clear reads zero", 64'(d), 64'h0);
      rd(A_MCLR_HI, d);
      chk("R8 missed-clear reads zero", 64'(d), 64'h0);
      repeat (5) @(negedge clk);
      chk("R7 valid held without ready", 64'(sub_valid), 64'h1);
      chk("R7 index held without ready", 64'(sub_idx), 64'd7);
      rd_pend(v);
      chk("R3 no clear without handshake", v, 64'h0000_0002_0000_0080);
      drain();
   endtask

   task automatic t_repeat_miss();
      logic [63:0] v;
      wr(A_SET_LO, 32'h0000_0004);
      wr(A_SET_LO, 32'h0000_0004);
      rd_miss(v);
      chk("R5 repeat write sets miss", v, 64'h4);
      rd_pend(v);
      chk("R5 pending kept after repeat", v, 64'h4);
      wr(A_MCLR_LO, 32'h0);
      rd_miss(v);
      chk("R6 miss sticky with zero clear", v, 64'h4);
      wr(A_ECLR_LO, 32'hFFFF_FFFF);
      rd_miss(v);
      chk("R6 miss kept by trigger clear", v, 64'h4);
      wr(A_MCLR_LO, 32'h0000_0004);
      rd_miss(v);
      chk("R6 miss cleared by W1C", v, 64'h0);
      drain();
   endtask

   task automatic t_tie();
      logic [63:0] v;
      wr(A_SET_LO, 32'h0000_0200);
      @(negedge clk);
      sub_ready = 1'b1; wr_en = 1'b1; wr_addr = A_SET_LO; wr_data = 32'h0000_0200;
      @(negedge clk);
      sub_ready = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd_pend(v);
      chk("R4 set beats clear same bit", v, 64'h200);
      rd_miss(v);
      chk("R4 same-bit tie records miss", v, 64'h200);
      drain();
      wr(A_SET_LO, 32'h0000_1000);
      @(negedge clk);
      sub_ready = 1'b1; wr_en = 1'b1; wr_addr = A_SET_LO; wr_data = 32'h0000_0400;
      @(negedge clk);
      sub_ready = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd_pend(v);
      chk("R4 other-bit tie pending", v, 64'h400);
      rd_miss(v);
      chk("R4 other-bit tie no miss", v, 64'h0);
      chk("R7 new bit offered", 64'(sub_idx), 64'd10);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_and_order();
      t_eclr_and_hold();
      t_repeat_miss();
      t_tie();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #500000;
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule